// File: doc/BRIEF.md
# Three-Mode Programmable Logic Output Macrocell

This block is one output slice of a sum-of-products programmable logic device. An external AND array delivers eight product terms to it. Two global mode bits choose among registered, complex and simple operation. Two per-cell configuration bits then make the slice one of the following:

- a registered output;
- a combinatorial output or I/O;
- a dedicated input.

The slice produces three signals: the value driven toward the pin, the tri-state enable, and the feedback bit returned to the array.

The slice's position in the row of cells is a parameter. In complex mode the two outer cells lose their feedback path. In simple mode the two middle cells are forced to drive. A polarity bit sets the sense of the combinatorial sum. The register clears low on reset and is inverted on its way to the pin. A preload strobe can force the register to a chosen value.

Top module: `pld_macrocell`

## Requirements
- R1: In registered mode (`mode_sel`=10) with a registered cell (`cell_cfg`=11), each rising clock edge loads the register with the OR of all eight product terms, and `pin_out` equals the inverse of the register.
- R2: For a registered cell in registered mode, `pin_oe` equals the inverse of the shared active-low `oe_pin_n`, and `fb_out` equals the inverse of the register.
- R3: In registered mode, a combinatorial cell (`cell_cfg` 01 or 10) sets `pin_oe` = `pt[0]`, drives the OR of `pt[7:1]` through the polarity stage, and sets `fb_out` = `pin_in`.
- R4: A dedicated-input cell (`cell_cfg`=00) has `pin_oe` low in every mode, except for a centre cell in simple mode.
- R5: In complex mode (`mode_sel`=01), every non-input cell, including one configured as registered, sets `pin_oe` = `pt[0]` and drives the OR of `pt[7:1]` through the polarity stage.
- R6: In complex mode, `fb_out` is 0 for the two edge cells (index 0 and NUM_CELLS-1) and equals `pin_in` for the inner cells.
- R7: In simple mode (`mode_sel`=00), the sum is the OR of all eight terms and non-input cells have `pin_oe`=1. The centre cells (index NUM_CELLS/2-1 and NUM_CELLS/2) always drive, with `fb_out`=0. Other cells feed back `pin_in`.
- R8: The combinatorial `pin_out` equals the sum when `pol_hi`=1 and its inverse when `pol_hi`=0.
- R9: With `rst_n` low at a rising edge, the register clears to 0, so a registered pin reads 1. Reset takes priority over preload.
- R10: With `pl_en` high at a rising edge and reset inactive, the register loads `pl_val` in place of the sum for that cycle.
- R11: Mode code 11 behaves exactly as simple mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Global mode: 00 simple, 01 complex, 10 registered, 11 simple |
| cell_cfg | input | 2 | Cell kind: 00 input, 01 comb output, 10 comb I/O, 11 registered |
| pol_hi | input | 1 | Combinatorial polarity, 1 = active-high |
| pt | input | NUM_PT | Product terms from the AND array |
| oe_pin_n | input | 1 | Shared active-low output enable for registered cells |
| pin_in | input | 1 | Current pin level for feedback |
| pl_en | input | 1 | Preload strobe |
| pl_val | input | 1 | Preload value |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Tri-state enable, 1 = drive |
| fb_out | output | 1 | Feedback into the AND array |

## Verification
The assertions assume that `mode_sel` and `cell_cfg` carry only the four listed codes. They also assume that `pl_en`, `pl_val` and the product terms are settled before each rising edge. The bench meets both assumptions by changing every input only on the falling edge, half a period away from the register update. It draws the configuration codes from the full two-bit range. Three copies of the slice run side by side on the same stimulus: an edge cell, an inner cell and a centre cell. This makes every position-dependent rule visible under the same input patterns.

// File: rtl/pld_mc_pkg.sv
// Shared types for the output macrocell slice.
// Assumes: mode and cell codes are static configuration.
package pld_mc_pkg;

    typedef enum logic [1:0] {
        MODE_SIMPLE     = 2'b00,
        MODE_COMPLEX    = 2'b01,
        MODE_REGISTERED = 2'b10,
        MODE_SIMPLE_ALT = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        CELL_INPUT    = 2'b00,
        CELL_COMB_OUT = 2'b01,
        CELL_COMB_IO  = 2'b10,
        CELL_REG      = 2'b11
    } cell_e;

    function automatic logic is_simple(mode_e m);
        return (m == MODE_SIMPLE) || (m == MODE_SIMPLE_ALT);
    endfunction

endpackage

// File: rtl/pld_mc_pt_split.sv
// Product-term splitter: forms the full sum, the reduced sum that excludes
// the enable term, and the enable term itself.
// Assumes: NUM_PT >= 2 and the enable term sits at index OE_IDX = 0.
module pld_mc_pt_split #(
    parameter int NUM_PT = 8
) (
    input  logic [NUM_PT-1:0] pt,
    output logic              sum_all,
    output logic              sum_rest,
    output logic              oe_term
);
    localparam int OE_IDX = 0;

    logic [NUM_PT-1:0] chain;

    // OR chain over the upper terms; the lowest term is added only for the full sum.
    genvar g;
    generate
        for (g = NUM_PT - 1; g > OE_IDX; g--) begin : g_or
            if (g == NUM_PT - 1) begin : g_top
                assign chain[g] = pt[g];
            end else begin : g_mid
                assign chain[g] = chain[g+1] | pt[g];
            end
        end
    endgenerate
    assign chain[OE_IDX] = chain[OE_IDX+1] | pt[OE_IDX];

    // Purpose: expose the three views of the product terms.
    always_comb begin
        sum_rest = chain[OE_IDX+1];
        sum_all  = chain[OE_IDX];
        oe_term  = pt[OE_IDX];
    end
endmodule

// File: rtl/pld_mc_reg.sv
// Macrocell storage flop: synchronous active-low clear, then preload, then sum.
// Assumes: pl_en and pl_val settle before the rising edge.
module pld_mc_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    input  logic pl_en,
    input  logic pl_val,
    output logic q
);
    // Purpose: next-state register with reset priority over preload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (pl_en) begin
            q <= pl_val;
        end else begin
            q <= d;
        end
    end

    // R9: a reset edge leaves the flop low
    p_reset_low_r9: assert property (@(posedge clk)
        !rst_n |=> (q == 1'b0));

    // R10: a preload strobe overrides the sum for one edge
    p_preload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && pl_en) |=> (q == $past(pl_val)));

    // R1: without preload the flop follows the sum
    p_sum_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !pl_en) |=> (q == $past(d)));
endmodule

// File: rtl/pld_mc_route.sv
// Output routing: picks pin value, enable and feedback source by mode,
// cell kind and the slice's position in the row.
// Assumes: CELL_IDX < NUM_CELLS and NUM_CELLS is even and >= 4.
module pld_mc_route
    import pld_mc_pkg::*;
#(
    parameter int NUM_CELLS = 8,
    parameter int CELL_IDX  = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  cell_e cfg,
    input  logic  pol_hi,
    input  logic  sum_all,
    input  logic  sum_rest,
    input  logic  oe_term,
    input  logic  q,
    input  logic  oe_pin_n,
    input  logic  pin_in,
    output logic  pin_out,
    output logic  pin_oe,
    output logic  fb_out
);
    localparam bit IS_EDGE   = (CELL_IDX == 0) || (CELL_IDX == NUM_CELLS - 1);
    localparam bit IS_CENTRE = (CELL_IDX == NUM_CELLS/2 - 1) || (CELL_IDX == NUM_CELLS/2);

    logic simple_m;
    logic reg_path;
    logic comb_sum;
    logic comb_val;
    logic no_fb;
    logic force_drive;

    // Position-dependent structure: which cells lose feedback or must drive.
    generate
        if (IS_EDGE) begin : g_edge
            assign no_fb       = (mode == MODE_COMPLEX);
            assign force_drive = 1'b0;
        end else if (IS_CENTRE) begin : g_centre
            assign no_fb       = simple_m;
            assign force_drive = simple_m;
        end else begin : g_inner
            assign no_fb       = 1'b0;
            assign force_drive = 1'b0;
        end
    endgenerate

    // Purpose: mode decode and combinatorial sum with polarity.
    always_comb begin
        simple_m = is_simple(mode);
        reg_path = (mode == MODE_REGISTERED) && (cfg == CELL_REG);
        comb_sum = simple_m ? sum_all : sum_rest;
        comb_val = pol_hi ? comb_sum : ~comb_sum;
    end

    // Purpose: select pin value, enable and feedback.
    always_comb begin
        pin_out = reg_path ? ~q : comb_val;

        if (force_drive) begin
            pin_oe = 1'b1;
        end else if (cfg == CELL_INPUT) begin
            pin_oe = 1'b0;
        end else if (simple_m) begin
            pin_oe = 1'b1;
        end else if (reg_path) begin
            pin_oe = ~oe_pin_n;
        end else begin
            pin_oe = oe_term;
        end

        if (reg_path) begin
            fb_out = ~q;
        end else if (no_fb) begin
            fb_out = 1'b0;
        end else begin
            fb_out = pin_in;
        end
    end

    // R4: an input cell never drives unless it is a centre cell in simple mode
    p_input_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == CELL_INPUT && !(IS_CENTRE && is_simple(mode))) |-> !pin_oe);

    // R2: a registered cell follows the shared enable pin
    p_reg_oe_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_REGISTERED && cfg == CELL_REG) |-> (pin_oe == !oe_pin_n));

    // R2: feedback and pin of a registered cell agree (both inverted flop)
    p_reg_fb_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_REGISTERED && cfg == CELL_REG) |-> (fb_out == pin_out));

    generate
        if (IS_EDGE) begin : g_edge_chk
            // R6: edge cells have no feedback in complex mode
            p_complex_edge_nofb_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == MODE_COMPLEX) |-> !fb_out);
        end
        if (IS_CENTRE) begin : g_centre_chk
            // R7: centre cells always drive in simple mode
            p_simple_centre_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
                is_simple(mode) |-> (pin_oe && !fb_out));
        end
    endgenerate
endmodule

// File: rtl/pld_macrocell.sv
// Top of one output macrocell slice: splits product terms, holds the
// register and routes pin, enable and feedback.
// Assumes: configuration inputs are static during normal operation.
module pld_macrocell
    import pld_mc_pkg::*;
#(
    parameter int NUM_PT    = 8,
    parameter int NUM_CELLS = 8,
    parameter int CELL_IDX  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic [1:0]        cell_cfg,
    input  logic              pol_hi,
    input  logic [NUM_PT-1:0] pt,
    input  logic              oe_pin_n,
    input  logic              pin_in,
    input  logic              pl_en,
    input  logic              pl_val,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fb_out
);
    logic  sum_all;
    logic  sum_rest;
    logic  oe_term;
    logic  q;
    mode_e mode;
    cell_e cfg;

    // Purpose: map raw configuration codes onto the shared types.
    always_comb begin
        mode = mode_e'(mode_sel);
        cfg  = cell_e'(cell_cfg);
    end

    pld_mc_pt_split #(.NUM_PT(NUM_PT)) i_split (
        .pt       (pt),
        .sum_all  (sum_all),
        .sum_rest (sum_rest),
        .oe_term  (oe_term)
    );

    pld_mc_reg i_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (sum_all),
        .pl_en  (pl_en),
        .pl_val (pl_val),
        .q      (q)
    );

    pld_mc_route #(.NUM_CELLS(NUM_CELLS), .CELL_IDX(CELL_IDX)) i_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .cfg      (cfg),
        .pol_hi   (pol_hi),
        .sum_all  (sum_all),
        .sum_rest (sum_rest),
        .oe_term  (oe_term),
        .q        (q),
        .oe_pin_n (oe_pin_n),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .fb_out   (fb_out)
    );

    // R11: mode code 11 gives the same enable as simple for a non-input cell
    p_alt_simple_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11 && cell_cfg != 2'b00) |-> pin_oe);
endmodule

// File: tb/test_pld_macrocell.sv
`timescale 1ns/1ps
module test_pld_macrocell;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_sel;
    logic [1:0] cell_cfg;
    logic       pol_hi;
    logic [7:0] pt;
    logic       oe_pin_n;
    logic       pin_in;
    logic       pl_en;
    logic       pl_val;

    logic out_i, oe_i, fb_i;
    logic out_e, oe_e, fb_e;
    logic out_c, oe_c, fb_c;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic mq;
    bit  mq_valid = 1'b0;

    always #2.5 clk = ~clk;

    pld_macrocell #(.CELL_IDX(2)) i_pld_macrocell (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cell_cfg(cell_cfg),
        .pol_hi(pol_hi), .pt(pt), .oe_pin_n(oe_pin_n), .pin_in(pin_in),
        .pl_en(pl_en), .pl_val(pl_val),
        .pin_out(out_i), .pin_oe(oe_i), .fb_out(fb_i));

    pld_macrocell #(.CELL_IDX(0)) i_pld_macrocell_edge (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cell_cfg(cell_cfg),
        .pol_hi(pol_hi), .pt(pt), .oe_pin_n(oe_pin_n), .pin_in(pin_in),
        .pl_en(pl_en), .pl_val(pl_val),
        .pin_out(out_e), .pin_oe(oe_e), .fb_out(fb_e));

    pld_macrocell #(.CELL_IDX(3)) i_pld_macrocell_centre (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cell_cfg(cell_cfg),
        .pol_hi(pol_hi), .pt(pt), .oe_pin_n(oe_pin_n), .pin_in(pin_in),
        .pl_en(pl_en), .pl_val(pl_val),
        .pin_out(out_c), .pin_oe(oe_c), .fb_out(fb_c));

    // Behavioural register model (R1, R9, R10)
    always @(posedge clk) begin
        if (!rst_n)     mq <= 1'b0;
        else if (pl_en) mq <= pl_val;
        else            mq <= |pt;
        mq_valid <= 1'b1;
    end

    // Expected {pin_out, pin_oe, fb_out} for a cell at position idx in a row of eight
    function automatic logic [2:0] expect_cell(int idx);
        bit edge_c   = (idx == 0) || (idx == 7);
        bit centre_c = (idx == 3) || (idx == 4);
        bit simple_m = (mode_sel == 2'b00) || (mode_sel == 2'b11);
        bit regp     = (mode_sel == 2'b10) && (cell_cfg == 2'b11);
        logic s, o, e, f;
        s = simple_m ? (|pt) : (|pt[7:1]);
        o = regp ? !mq : (pol_hi ? s : !s);
        if (simple_m)              e = centre_c ? 1'b1 : (cell_cfg != 2'b00);
        else if (cell_cfg == 2'b00) e = 1'b0;
        else if (regp)             e = !oe_pin_n;
        else                       e = pt[0];
        if (regp)                                 f = !mq;
        else if (mode_sel == 2'b01 && edge_c)     f = 1'b0;
        else if (simple_m && centre_c)            f = 1'b0;
        else                                      f = pin_in;
        return {o, e, f};
    endfunction

    // Requirement tag for a given output (0 out, 1 oe, 2 fb)
    function automatic string tag_for(int which);
        if (mode_sel == 2'b11) return "R11";
        if (mode_sel == 2'b10 && cell_cfg == 2'b11) return (which == 0) ? "R1" : "R2";
        if (which == 1 && cell_cfg == 2'b00) return "R4";
        if (which == 0 && !pol_hi) return "R8";
        if (mode_sel == 2'b10) return "R3";
        if (mode_sel == 2'b01) return (which == 2) ? "R6" : "R5";
        return "R7";
    endfunction

    task automatic check1(string tg, string nm, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (mode %b cfg %b pt %h)",
                     tg, nm, act, exp, mode_sel, cell_cfg, pt);
        end
    endtask

    task automatic compare_all();
        logic [2:0] xi, xe, xc;
        xi = expect_cell(2);
        xe = expect_cell(0);
        xc = expect_cell(3);
        check1(tag_for(0), "inner.out",  out_i, xi[2]);
        check1(tag_for(1), "inner.oe",   oe_i,  xi[1]);
        check1(tag_for(2), "inner.fb",   fb_i,  xi[0]);
        check1(tag_for(0), "edge.out",   out_e, xe[2]);
        check1(tag_for(1), "edge.oe",    oe_e,  xe[1]);
        check1(tag_for(2), "edge.fb",    fb_e,  xe[0]);
        check1(tag_for(0), "centre.out", out_c, xc[2]);
        check1(tag_for(1), "centre.oe",  oe_c,  xc[1]);
        check1(tag_for(2), "centre.fb",  fb_c,  xc[0]);
    endtask

    task automatic run_phase(logic [1:0] m, int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (mq_valid) compare_all();
            mode_sel = m;
            cell_cfg = 2'($urandom);
            pol_hi   = 1'($urandom);
            case ($urandom % 4)
                0:       pt = 8'h00;
                1:       pt = 8'h01 << ($urandom % 8);
                2:       pt = 8'h01;
                default: pt = 8'($urandom);
            endcase
            oe_pin_n = 1'($urandom);
            pin_in   = 1'($urandom);
            pl_en    = (($urandom % 6) == 0);
            pl_val   = 1'($urandom);
            rst_n    = (($urandom % 40) != 0);
        end
    endtask

    initial begin
        rst_n = 1'b0; mode_sel = 2'b10; cell_cfg = 2'b11; pol_hi = 1'b1;
        pt = 8'hFF; oe_pin_n = 1'b0; pin_in = 1'b0; pl_en = 1'b0; pl_val = 1'b0;
        // R9: register clears under reset, registered pin reads high
        @(negedge clk); @(negedge clk);
        check1("R9", "inner.out after reset", out_i, 1'b1);
        check1("R9", "edge.out after reset",  out_e, 1'b1);
        check1("R2", "inner.oe with oe pin low", oe_i, 1'b1);
        // R10: preload forces 1 while the sum is 0
        rst_n = 1'b1; pt = 8'h00; pl_en = 1'b1; pl_val = 1'b1;
        @(negedge clk);
        check1("R10", "inner.out after preload", out_i, 1'b0);
        check1("R10", "inner.fb after preload",  fb_i,  1'b0);
        // R1: back to the sum (0), then a single high term
        pl_en = 1'b0;
        @(negedge clk);
        check1("R1", "inner.out sum 0", out_i, 1'b1);
        pt = 8'h80;
        @(negedge clk);
        check1("R1", "inner.out sum 1", out_i, 1'b0);
        // R9: reset beats a simultaneous preload
        rst_n = 1'b0; pl_en = 1'b1; pl_val = 1'b1;
        @(negedge clk);
        check1("R9", "inner.out reset over preload", out_i, 1'b1);
        rst_n = 1'b1; pl_en = 1'b0;

        run_phase(2'b10, 600);
        run_phase(2'b01, 400);
        run_phase(2'b00, 400);
        run_phase(2'b11, 300);
        @(negedge clk);
        compare_all();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule